// File: doc/BRIEF.md
# Interrupt Factor Flag Controller

This block is the peripheral side of interrupt handling for a small 4-bit microcontroller. Each interrupt source has a latched factor flag and an enable bit. The sources are four clock-timer taps, two stopwatch overflows, a programmable-timer-zero pulse, a serial-transfer-done pulse and two groups of external input pins. Software reaches the flags and enables through 4-bit registers on a simple register bus. Reading a flag register returns its contents and clears the flags it returned. The block raises one request line to the CPU whenever a set flag meets its enable and the CPU's global interrupt-enable input is high.

The timer, stopwatch, programmable-timer and serial flags latch their events whether or not they are enabled. The two pin groups behave differently: they latch only through their own per-pin enables.
- Group 0 sets its flag while an enabled pin differs from a 4-bit reference value.
- Group 1 sets its flag on a falling edge of an enabled pin.

Pins of both groups pass through a two-flop synchronizer before they are compared or edge-detected.

Top module: `irq_factor_ctrl`

## Requirements
- R1: A one-cycle pulse on `ev_tap`, `ev_sw`, `ev_ptz` or `ev_sdone` sets the matching flag at the next clock edge, even when that flag's enable bit is 0. The flag then holds until it is cleared.
- R2: `irq` is 1 exactly when `cpu_ie` is 1 and at least one set flag is enabled. For the two pin-group flags, "enabled" means any of that group's four pin enables is 1.
- R3: A read strobe (`bus_rd`=1) at a flag address returns that register's flags on `bus_rdata` in the same cycle and clears them at the next edge. A bus read strobe at an enable address clears nothing.
- R4: The enable registers are read/write. A write stores only the implemented low bits, and unimplemented bits read back as 0. The widths are 4 bits at 0x10, 2 bits at 0x11, 1 bit at 0x12, 1 bit at 0x13, 4 bits at 0x14 and 4 bits at 0x15.
- R5: After a synchronous active-low reset, every flag, every enable bit and `irq` are 0.
- R6: The group-0 flag (0x04 bit 0) sets when the synchronized pins differ from `pg0_ref` on at least one pin whose enable in 0x14 is 1. Mismatches on masked pins are ignored. While an enabled mismatch persists, the flag sets again after each clearing read.
- R7: The group-1 flag (0x05 bit 0) sets on a falling edge of a synchronized pin whose enable in 0x15 is 1. Rising edges and edges on masked pins are ignored.
- R8: If an event arrives in the same cycle as a clearing read of its flag, the flag remains set after that edge.
- R9: The flag bit positions are as follows. At 0x00, bits 3..0 hold tap 3..0 (`ev_tap[i]` maps to bit i). At 0x01, bits 1..0 hold `ev_sw[1:0]`. Bit 0 holds `ev_ptz` at 0x02, `ev_sdone` at 0x03, group 0 at 0x04 and group 1 at 0x05.
- R10: Any address other than 0x00–0x05 and 0x10–0x15 reads as 0. Writes to flag addresses or to undefined addresses change no flag and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ie | input | 1 | CPU global interrupt-enable flag |
| ev_tap | input | 4 | Clock-timer tap falling-edge pulses (bit 3 = 1 Hz, 2 = 2 Hz, 1 = 8 Hz, 0 = 32 Hz) |
| ev_sw | input | 2 | Stopwatch overflow pulses (bit 1 = high digit, bit 0 = low digit) |
| ev_ptz | input | 1 | Programmable timer reached zero |
| ev_sdone | input | 1 | Serial 8-bit transfer done |
| pg0_pin | input | 4 | Pin group 0, asynchronous |
| pg0_ref | input | 4 | Reference value for pin group 0 |
| pg1_pin | input | 4 | Pin group 1, asynchronous |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 4 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle; clears the flags that are read |
| bus_rdata | output | 4 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
**Internal sources.** Each internal source is pulsed with its enable at 0, then with only a different bit enabled, then with its own bit enabled. These three cases separate three things:
- latching versus masking;
- the wrong enable bit being used;
- the global enable gating.

A pulse applied in the same cycle as a clearing read shows whether a clear can swallow a new event.

**Group 0.** The pins are driven to a mismatch on a masked pin, then on an enabled pin. The enabled mismatch is held across reads and then removed. This separates per-pin masking from level-sensitive re-setting.

**Group 1.** The pins are given falling and rising edges on masked and enabled pins. This separates edge detection from level or rising-edge detection.

// File: rtl/irqf_pkg.sv
// Package: shared constants for the interrupt factor flag controller.
// Holds the register addresses and the detector mode type.
package irqf_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 4;

    localparam logic [ADDR_W-1:0] A_FLG_TAP = 8'h00;
    localparam logic [ADDR_W-1:0] A_FLG_SW  = 8'h01;
    localparam logic [ADDR_W-1:0] A_FLG_PT  = 8'h02;
    localparam logic [ADDR_W-1:0] A_FLG_SIO = 8'h03;
    localparam logic [ADDR_W-1:0] A_FLG_G0  = 8'h04;
    localparam logic [ADDR_W-1:0] A_FLG_G1  = 8'h05;
    localparam logic [ADDR_W-1:0] A_EN_TAP  = 8'h10;
    localparam logic [ADDR_W-1:0] A_EN_SW   = 8'h11;
    localparam logic [ADDR_W-1:0] A_EN_PT   = 8'h12;
    localparam logic [ADDR_W-1:0] A_EN_SIO  = 8'h13;
    localparam logic [ADDR_W-1:0] A_EN_G0   = 8'h14;
    localparam logic [ADDR_W-1:0] A_EN_G1   = 8'h15;

    typedef enum logic {
        DET_MISMATCH = 1'b0,
        DET_FALL     = 1'b1
    } det_mode_e;
endpackage

// File: rtl/irqf_sync.sv
// Module: irqf_sync
// A multi-flop synchronizer for a bus of asynchronous pins.
// Assumes each bit is independent; no multi-bit coherence is promised.
module irqf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each later stage resolves metastability of the one before.
        always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/irqf_port_detect.sv
// Module: irqf_port_detect
// Synchronizes a pin group and produces a one-cycle-per-cycle event.
// In DET_MISMATCH mode the event is high while an enabled pin differs
// from ref_val. In DET_FALL mode it is high for a 1->0 step of an enabled pin.
// Assumes ref_val and en are already in the clk domain.
module irqf_port_detect
    import irqf_pkg::*;
#(
    parameter int        W      = 4,
    parameter int        STAGES = 2,
    parameter det_mode_e MODE   = DET_MISMATCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] en,
    output logic         evt
);
    logic [W-1:0] cur;
    logic [W-1:0] prev;
    logic [W-1:0] hit;

    irqf_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (cur)
    );

    // Previous synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    // Per-pin condition chosen by the mode parameter.
    always_comb begin
        if (MODE == DET_FALL) hit = prev & ~cur;
        else                  hit = cur ^ ref_val;
    end

    assign evt = |(hit & en);
endmodule

// File: rtl/irqf_flag_bank.sv
// Module: irqf_flag_bank
// A bank of N sticky factor flags. A set pulse latches a flag and a clear
// pulse drops it. Set wins over clear, so no event is lost to a read.
module irqf_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end

        // R1: an event always leaves its flag set.
        a_r1_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
        // R8: set in the same cycle as clear keeps the flag.
        a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && clr[i]) |=> flag[i]);
        // R3: a clear with no event drops the flag.
        a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flag[i]);
        // R1: without set or clear the flag holds its value.
        a_r1_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !clr[i]) |=> $stable(flag[i]));
    end
endmodule

// File: rtl/irq_factor_ctrl.sv
// Module: irq_factor_ctrl (top)
// Interrupt factor flags, enable registers and the CPU request line.
// Assumes all ev_* inputs are single-cycle pulses in the clk domain and that
// pin-group inputs are asynchronous. Bus strobes are one cycle wide.
// Read data is combinational from bus_addr.
module irq_factor_ctrl
    import irqf_pkg::*;
#(
    parameter int TAP_W       = 4,
    parameter int SW_W        = 2,
    parameter int PIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ie,
    input  logic [TAP_W-1:0]  ev_tap,
    input  logic [SW_W-1:0]   ev_sw,
    input  logic              ev_ptz,
    input  logic              ev_sdone,
    input  logic [PIN_W-1:0]  pg0_pin,
    input  logic [PIN_W-1:0]  pg0_ref,
    input  logic [PIN_W-1:0]  pg1_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int IDX_SW  = TAP_W;
    localparam int IDX_PT  = TAP_W + SW_W;
    localparam int IDX_SIO = IDX_PT + 1;
    localparam int IDX_G0  = IDX_SIO + 1;
    localparam int IDX_G1  = IDX_G0 + 1;
    localparam int N_FLAG  = IDX_G1 + 1;

    logic [TAP_W-1:0]  en_tap;
    logic [SW_W-1:0]   en_sw;
    logic              en_pt;
    logic              en_sio;
    logic [PIN_W-1:0]  en_g0;
    logic [PIN_W-1:0]  en_g1;
    logic              evt_g0;
    logic              evt_g1;
    logic [N_FLAG-1:0] set_v;
    logic [N_FLAG-1:0] clr_v;
    logic [N_FLAG-1:0] flag;
    logic [N_FLAG-1:0] en_v;

    // Pin group 0 mismatch detector.
    irqf_port_detect #(.W(PIN_W), .STAGES(SYNC_STAGES), .MODE(DET_MISMATCH)) u_g0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pg0_pin),
        .ref_val (pg0_ref),
        .en      (en_g0),
        .evt     (evt_g0)
    );

    // Pin group 1 falling-edge detector.
    irqf_port_detect #(.W(PIN_W), .STAGES(SYNC_STAGES), .MODE(DET_FALL)) u_g1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pg1_pin),
        .ref_val ('0),
        .en      (en_g1),
        .evt     (evt_g1)
    );

    // Gather the set pulses into flag-bank order.
    always_comb begin
        set_v                   = '0;
        set_v[TAP_W-1:0]        = ev_tap;
        set_v[IDX_SW+:SW_W]     = ev_sw;
        set_v[IDX_PT]           = ev_ptz;
        set_v[IDX_SIO]          = ev_sdone;
        set_v[IDX_G0]           = evt_g0;
        set_v[IDX_G1]           = evt_g1;
    end

    // A read strobe at a flag address clears that register's flags.
    always_comb begin
        clr_v = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_FLG_TAP: clr_v[TAP_W-1:0]    = '1;
                A_FLG_SW:  clr_v[IDX_SW+:SW_W] = '1;
                A_FLG_PT:  clr_v[IDX_PT]       = 1'b1;
                A_FLG_SIO: clr_v[IDX_SIO]      = 1'b1;
                A_FLG_G0:  clr_v[IDX_G0]       = 1'b1;
                A_FLG_G1:  clr_v[IDX_G1]       = 1'b1;
                default:   clr_v               = '0;
            endcase
        end
    end

    irqf_flag_bank #(.N(N_FLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .flag  (flag)
    );

    // Enable registers: bus writes store the implemented low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_tap <= '0;
            en_sw  <= '0;
            en_pt  <= 1'b0;
            en_sio <= 1'b0;
            en_g0  <= '0;
            en_g1  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_EN_TAP: en_tap <= bus_wdata[TAP_W-1:0];
                A_EN_SW:  en_sw  <= bus_wdata[SW_W-1:0];
                A_EN_PT:  en_pt  <= bus_wdata[0];
                A_EN_SIO: en_sio <= bus_wdata[0];
                A_EN_G0:  en_g0  <= bus_wdata[PIN_W-1:0];
                A_EN_G1:  en_g1  <= bus_wdata[PIN_W-1:0];
                default:  ;
            endcase
        end
    end

    // Per-flag enable; a pin group counts as enabled if any pin is.
    always_comb begin
        en_v                   = '0;
        en_v[TAP_W-1:0]        = en_tap;
        en_v[IDX_SW+:SW_W]     = en_sw;
        en_v[IDX_PT]           = en_pt;
        en_v[IDX_SIO]          = en_sio;
        en_v[IDX_G0]           = |en_g0;
        en_v[IDX_G1]           = |en_g1;
    end

    // Request to the CPU.
    assign irq = cpu_ie && |(flag & en_v);

    // Read-data multiplexer; undefined addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FLG_TAP: bus_rdata[TAP_W-1:0] = flag[TAP_W-1:0];
            A_FLG_SW:  bus_rdata[SW_W-1:0]  = flag[IDX_SW+:SW_W];
            A_FLG_PT:  bus_rdata[0]         = flag[IDX_PT];
            A_FLG_SIO: bus_rdata[0]         = flag[IDX_SIO];
            A_FLG_G0:  bus_rdata[0]         = flag[IDX_G0];
            A_FLG_G1:  bus_rdata[0]         = flag[IDX_G1];
            A_EN_TAP:  bus_rdata[TAP_W-1:0] = en_tap;
            A_EN_SW:   bus_rdata[SW_W-1:0]  = en_sw;
            A_EN_PT:   bus_rdata[0]         = en_pt;
            A_EN_SIO:  bus_rdata[0]         = en_sio;
            A_EN_G0:   bus_rdata[PIN_W-1:0] = en_g0;
            A_EN_G1:   bus_rdata[PIN_W-1:0] = en_g1;
            default:   bus_rdata            = '0;
        endcase
    end

    // R2: no request while the CPU has interrupts off.
    a_r2_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cpu_ie);
    // R5: reset leaves all flags and enables at zero.
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flag == '0 && en_tap == '0 && en_g0 == '0 && en_g1 == '0 && !irq));
    // R10: the tap enable register changes only through a write to its address.
    a_r10_en_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_EN_TAP) |=> $stable(en_tap));
    // R7: the group-1 flag can only rise when some group-1 pin was enabled.
    a_r7_g1_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[IDX_G1]) |-> $past(|en_g1));
    // R6: the group-0 flag can only rise when some group-0 pin was enabled.
    a_r6_g0_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[IDX_G0]) |-> $past(|en_g0));
endmodule

// File: tb/sim_irq_factor_ctrl.sv
// Directed bench for irq_factor_ctrl: one task per scenario.
module sim_irq_factor_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ie = 1'b0;
    logic [3:0] ev_tap = '0;
    logic [1:0] ev_sw = '0;
    logic       ev_ptz = 1'b0;
    logic       ev_sdone = 1'b0;
    logic [3:0] pg0_pin = '0;
    logic [3:0] pg0_ref = '0;
    logic [3:0] pg1_pin = 4'hF;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_factor_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_ie(cpu_ie),
        .ev_tap(ev_tap), .ev_sw(ev_sw), .ev_ptz(ev_ptz), .ev_sdone(ev_sdone),
        .pg0_pin(pg0_pin), .pg0_ref(pg0_ref), .pg1_pin(pg1_pin),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Clearing read: sample in the strobe cycle, clear lands at the edge.
    task automatic bus_read(input logic [7:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tap(input logic [3:0] v);
        @(negedge clk);
        ev_tap = v;
        @(negedge clk);
        ev_tap = '0;
    endtask

    // R5: everything reads zero after reset.
    task automatic t_reset();
        logic [3:0] d;
        for (int a = 0; a < 6; a++) begin
            bus_read(8'(a), d);
            check("R5 flag reset", d, 0);
            bus_read(8'(a + 16), d);
            check("R5 enable reset", d, 0);
        end
        #1 check("R5 irq reset", irq, 0);
    endtask

    // R1/R9/R3: masked events latch at their bit positions, reads clear.
    task automatic t_latch_map();
        logic [3:0] d;
        pulse_tap(4'b1000);
        bus_read(8'h00, d); check("R1 R9 tap bit3 latched while masked", d, 4'b1000);
        bus_read(8'h00, d); check("R3 tap flags cleared by read", d, 0);
        pulse_tap(4'b0101);
        bus_read(8'h10, d); check("R3 enable read returns enables", d, 0);
        bus_read(8'h00, d); check("R3 enable read does not clear flags", d, 4'b0101);
        @(negedge clk); ev_sw = 2'b01; @(negedge clk); ev_sw = '0;
        bus_read(8'h01, d); check("R9 stopwatch low digit at bit0", d, 4'b0001);
        @(negedge clk); ev_sw = 2'b10; @(negedge clk); ev_sw = '0;
        bus_read(8'h01, d); check("R9 stopwatch high digit at bit1", d, 4'b0010);
        @(negedge clk); ev_ptz = 1'b1; @(negedge clk); ev_ptz = 1'b0;
        bus_read(8'h03, d); check("R9 serial flag clear before its event", d, 0);
        bus_read(8'h02, d); check("R1 R9 timer-zero flag", d, 1);
        @(negedge clk); ev_sdone = 1'b1; @(negedge clk); ev_sdone = 1'b0;
        bus_read(8'h03, d); check("R1 R9 serial flag", d, 1);
        bus_read(8'h03, d); check("R3 serial flag cleared", d, 0);
    endtask

    // R4: enable register widths.
    task automatic t_enables();
        logic [3:0] d;
        bus_write(8'h10, 4'hF); bus_read(8'h10, d); check("R4 en 0x10", d, 4'hF);
        bus_write(8'h11, 4'hF); bus_read(8'h11, d); check("R4 en 0x11 width 2", d, 4'h3);
        bus_write(8'h12, 4'hF); bus_read(8'h12, d); check("R4 en 0x12 width 1", d, 4'h1);
        bus_write(8'h13, 4'hE); bus_read(8'h13, d); check("R4 en 0x13 bit0 only", d, 4'h0);
        bus_write(8'h14, 4'hA); bus_read(8'h14, d); check("R4 en 0x14", d, 4'hA);
        bus_write(8'h15, 4'h5); bus_read(8'h15, d); check("R4 en 0x15", d, 4'h5);
        for (int a = 16; a < 22; a++) bus_write(8'(a), 4'h0);
        bus_read(8'h11, d); check("R4 en 0x11 cleared", d, 0);
    endtask

    // R2: request gating by enable bit and global enable.
    task automatic t_irq();
        logic [3:0] d;
        bus_write(8'h10, 4'b0010);
        cpu_ie = 1'b1;
        pulse_tap(4'b0001);
        #1 check("R2 flag on other bit gives no irq", irq, 0);
        bus_read(8'h00, d);
        @(negedge clk); cpu_ie = 1'b0;
        pulse_tap(4'b0010);
        #1 check("R2 no irq while cpu_ie low", irq, 0);
        @(negedge clk); cpu_ie = 1'b1;
        #1 check("R2 irq with flag, enable and cpu_ie", irq, 1);
        bus_read(8'h00, d);
        #1 check("R2 irq drops after clearing read", irq, 0);
        cpu_ie = 1'b0;
        bus_write(8'h10, 4'h0);
    endtask

    // R8: event in the same cycle as the clearing read survives.
    task automatic t_collide();
        logic [3:0] d;
        @(negedge clk);
        bus_addr = 8'h00; bus_rd = 1'b1; ev_tap = 4'b0001;
        #1 d = bus_rdata;
        check("R8 read before collision sees empty", d, 0);
        @(negedge clk);
        bus_rd = 1'b0; ev_tap = '0;
        bus_read(8'h00, d); check("R8 flag survives colliding read", d, 4'b0001);
    endtask

    // R6: mismatch group with per-pin masking and level re-set.
    task automatic t_group0();
        logic [3:0] d;
        bus_write(8'h14, 4'b0100);
        @(negedge clk); pg0_pin = 4'b0001;
        wait_cycles(5);
        bus_read(8'h04, d); check("R6 masked mismatch ignored", d, 0);
        @(negedge clk); pg0_pin = 4'b0101;
        wait_cycles(5);
        bus_read(8'h04, d); check("R6 enabled mismatch sets flag", d, 1);
        bus_read(8'h04, d); check("R6 persisting mismatch sets again", d, 1);
        @(negedge clk); pg0_ref = 4'b0100;
        wait_cycles(5);
        bus_read(8'h04, d);
        bus_read(8'h04, d); check("R6 match on enabled pin leaves flag clear", d, 0);
        bus_write(8'h14, 4'h0);
        pg0_pin = '0; pg0_ref = '0;
    endtask

    // R7: falling-edge group.
    task automatic t_group1();
        logic [3:0] d;
        bus_write(8'h15, 4'b0001);
        @(negedge clk); pg1_pin = 4'b0111;
        wait_cycles(5);
        bus_read(8'h05, d); check("R7 fall on masked pin ignored", d, 0);
        @(negedge clk); pg1_pin = 4'b1110;
        wait_cycles(5);
        cpu_ie = 1'b1;
        #1 check("R2 irq from enabled group-1 flag", irq, 1);
        cpu_ie = 1'b0;
        bus_read(8'h05, d); check("R7 fall on enabled pin sets flag", d, 1);
        bus_read(8'h05, d); check("R7 flag not re-set by held low", d, 0);
        @(negedge clk); pg1_pin = 4'b1111;
        wait_cycles(5);
        bus_read(8'h05, d); check("R7 rising edge ignored", d, 0);
        bus_write(8'h15, 4'h0);
    endtask

    // R10: undefined addresses and writes to flags.
    task automatic t_undefined();
        logic [3:0] d;
        pulse_tap(4'b0100);
        bus_write(8'h00, 4'h0);
        bus_write(8'h20, 4'hF);
        bus_write(8'h90, 4'hF);
        bus_read(8'h00, d); check("R10 write to flag register ignored", d, 4'b0100);
        bus_read(8'h20, d); check("R10 undefined 0x20 reads zero", d, 0);
        bus_read(8'h06, d); check("R10 undefined 0x06 reads zero", d, 0);
        bus_read(8'hFF, d); check("R10 undefined 0xFF reads zero", d, 0);
        bus_read(8'h10, d); check("R10 stray writes leave enables", d, 0);
    endtask

    initial begin
        fork
            begin
                wait_cycles(4);
                @(negedge clk); rst_n = 1'b1;
                t_reset();
                t_latch_map();
                t_enables();
                t_irq();
                t_collide();
                t_group0();
                t_group1();
                t_undefined();
                done = 1'b1;
            end
            begin
                #(CLK_PERIOD * 100000);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule